// File: doc/BRIEF.md
# PROM Write-Verify Programming Sequencer

This block is the host-side controller that writes a one-time or UV-erasable PROM through its parallel programming pins. A request names a target address and carries either one byte or a four-byte page. The sequencer then drives the chip-enable, output-enable and program-strobe pins, the address bus and the data bus through the required phases. For a page, it first latches four address/data pairs into the memory. It then applies a fixed-width program pulse and reads back every written location. If any location reads wrong, it repeats the pulse and the read-back, up to a bounded number of attempts.

When the block is idle, the memory sits in standby. The host sees a busy flag, a done or fail result that stays set until the next request, and the number of program pulses the request used. The pulse length is a count of clock cycles, derived from the clock frequency and the pulse width in microseconds. A nonzero override replaces that count, so that a bench can run with short pulses. Pin levels are active-low as on the memory: `dev_ce_o`, `dev_oe_o` and `dev_pgm_o` are low when asserted.

Top module: `prom_prog_seq`

## Requirements
- R1: While reset is held, and when reset is released, the pins are in standby: CE=1, OE=1, PGM=1 and data_en=0. Busy, done and fail read 0, and attempts reads 0.
- R2: Each program pulse holds PGM low for exactly PULSE_CYC consecutive cycles. PULSE_CYC is CLK_HZ/1e6*PULSE_US, or PULSE_CYC_OVR when that is nonzero. While PGM is low, OE is 1 and data_en is 1.
- R3: Page mode (page_i=1) starts with four latch cycles, one per slot k=0,1,2,3 in that order. Each has CE=1, PGM=1 and OE=0, with address base+k and data data_i[8k+7:8k]. The pulse that follows has CE=1 and OE=1.
- R4: In byte mode (page_i=0) there are no latch cycles. The pulse has CE=0 and OE=1, with address addr_i and data data_i[7:0].
- R5: Read-back occurs with CE=0 and OE=0. The data bus is released (data_en=0) in every cycle where CE and OE are both low.
- R6: In page mode, read-back checks the slots in order 0 to 3. The first mismatch triggers a new pulse for the whole page, without new latch cycles.
- R7: When every checked location matches, the block returns to idle with done=1, fail=0, and attempts equal to the number of pulses applied. Done and fail are never 1 together.
- R8: If the read-back after the MAX_TRIES-th pulse (10) still mismatches, the block returns to idle with fail=1 and attempts=10. It never applies more than MAX_TRIES pulses.
- R9: start_i is ignored while busy=1: the request in progress runs to completion unchanged.
- R10: Whenever busy=0, CE=1 (standby).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted only when idle |
| page_i | input | 1 | 1 = four-byte page, 0 = single byte |
| addr_i | input | ADDR_W | Target address (page base) |
| data_i | input | PAGE_N*DATA_W | Write data; byte k at bits 8k+7:8k |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Last request verified |
| fail_o | output | 1 | Last request exhausted its attempts |
| attempts_o | output | ATT_W | Program pulses used by the request |
| dev_ce_o | output | 1 | Memory chip enable (active low) |
| dev_oe_o | output | 1 | Memory output enable (active low) |
| dev_pgm_o | output | 1 | Memory program strobe (active low) |
| dev_addr_o | output | ADDR_W | Memory address bus |
| dev_data_o | output | DATA_W | Data driven toward the memory |
| dev_data_en_o | output | 1 | Drive enable for dev_data_o |
| dev_data_i | input | DATA_W | Data read back from the memory |

## Verification
The bound checker watches, on every cycle, the pin rules that never depend on the data. The program strobe is low only with OE high and the bus driven. The bus is released whenever CE and OE are both low. The pulse width equals PULSE_CYC exactly. CE is in standby whenever the block is idle. The attempt counter never passes the limit, and done and fail are exclusive. The bench's scenarios, run against a memory model whose cells need a chosen number of pulses, show the rest: the order of the latch addresses and data, the CE level that separates byte pulses from page pulses, whole-page retries without re-latching, success on exactly the tenth pulse versus failure after it, and a start strobe that arrives mid-request having no effect.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LATCH, ST_SETUP, ST_PULSE, ST_RELEASE, ST_SETTLE, ST_CHECK
  } seq_state_e;

  typedef struct packed {
    logic ce;
    logic oe;
    logic pgm;
    logic drive;
  } pin_set_t;
endpackage

// File: rtl/prom_pulse_timer.sv
module prom_pulse_timer #(
  parameter int CYC = 8,
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= W'(CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/prom_slot_mux.sv
module prom_slot_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_N = 4,
  parameter int SLOT_W = 2
) (
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [PAGE_N*DATA_W-1:0] data_i,
  input  logic [SLOT_W-1:0]        slot_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [DATA_W-1:0]        byte_o
);
  logic [DATA_W-1:0] bytes [PAGE_N];

  for (genvar gi = 0; gi < PAGE_N; gi++) begin : g_unpack
    assign bytes[gi] = data_i[gi*DATA_W +: DATA_W];
  end

  assign addr_o = base_i + ADDR_W'(slot_i);
  assign byte_o = bytes[slot_i];
endmodule

// File: rtl/prom_pin_decode.sv
module prom_pin_decode
  import prom_prog_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       page_i,
  output pin_set_t   pins_o
);
  always_comb begin
    pins_o = '{ce: 1'b1, oe: 1'b1, pgm: 1'b1, drive: 1'b0};
    unique case (state_i)
      ST_LATCH:   pins_o = '{ce: 1'b1,    oe: 1'b0, pgm: 1'b1, drive: 1'b1};
      ST_SETUP:   pins_o = '{ce: page_i,  oe: 1'b1, pgm: 1'b1, drive: 1'b1};
      ST_PULSE:   pins_o = '{ce: page_i,  oe: 1'b1, pgm: 1'b0, drive: 1'b1};
      ST_RELEASE: pins_o = '{ce: 1'b0,    oe: 1'b1, pgm: 1'b1, drive: 1'b0};
      ST_SETTLE,
      ST_CHECK:   pins_o = '{ce: 1'b0,    oe: 1'b0, pgm: 1'b1, drive: 1'b0};
      default:    ;
    endcase
  end
endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_prog_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PAGE_N        = 4,
  parameter int CLK_HZ        = 200_000_000,
  parameter int PULSE_US      = 100,
  parameter int PULSE_CYC_OVR = 0,
  parameter int MAX_TRIES     = 10,
  localparam int ATT_W        = $clog2(MAX_TRIES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     page_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [PAGE_N*DATA_W-1:0] data_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [ATT_W-1:0]         attempts_o,
  output logic                     dev_ce_o,
  output logic                     dev_oe_o,
  output logic                     dev_pgm_o,
  output logic [ADDR_W-1:0]        dev_addr_o,
  output logic [DATA_W-1:0]        dev_data_o,
  output logic                     dev_data_en_o,
  input  logic [DATA_W-1:0]        dev_data_i
);
  localparam int PULSE_CYC = (PULSE_CYC_OVR != 0) ? PULSE_CYC_OVR
                                                  : (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int SLOT_W    = (PAGE_N > 1) ? $clog2(PAGE_N) : 1;

  seq_state_e               state_q;
  logic                     page_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [PAGE_N*DATA_W-1:0] data_q;
  logic [SLOT_W-1:0]        slot_q;
  logic [ATT_W-1:0]         att_q;
  logic                     done_q, fail_q;

  logic              pulse_end;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_byte;
  pin_set_t          pins;

  prom_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_SETUP),
    .expired_o (pulse_end)
  );

  prom_slot_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_N(PAGE_N), .SLOT_W(SLOT_W)
  ) u_mux (
    .base_i (addr_q),
    .data_i (data_q),
    .slot_i (slot_q),
    .addr_o (slot_addr),
    .byte_o (slot_byte)
  );

  prom_pin_decode u_pins (
    .state_i (state_q),
    .page_i  (page_q),
    .pins_o  (pins)
  );

  logic last_slot, mismatch;
  assign last_slot = !page_q || (slot_q == SLOT_W'(PAGE_N - 1));
  assign mismatch  = (dev_data_i != slot_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      slot_q  <= '0;
      att_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          page_q  <= page_i;
          addr_q  <= addr_i;
          data_q  <= data_i;
          slot_q  <= '0;
          att_q   <= '0;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          state_q <= page_i ? ST_LATCH : ST_SETUP;
        end
        ST_LATCH: begin
          if (last_slot) begin
            slot_q  <= '0;
            state_q <= ST_SETUP;
          end else begin
            slot_q  <= slot_q + 1'b1;
          end
        end
        ST_SETUP: begin
          att_q   <= att_q + 1'b1;
          state_q <= ST_PULSE;
        end
        ST_PULSE: if (pulse_end) begin
          slot_q  <= '0;
          state_q <= ST_RELEASE;
        end
        ST_RELEASE: state_q <= ST_SETTLE;
        ST_SETTLE:  state_q <= ST_CHECK;
        ST_CHECK: begin
          if (mismatch) begin
            slot_q <= '0;
            if (att_q == ATT_W'(MAX_TRIES)) begin
              fail_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_SETUP;  // whole page re-pulsed, latch kept
            end
          end else if (last_slot) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= ST_SETTLE;  // new address needs a settle cycle
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign fail_o        = fail_q;
  assign attempts_o    = att_q;
  assign dev_ce_o      = pins.ce;
  assign dev_oe_o      = pins.oe;
  assign dev_pgm_o     = pins.pgm;
  assign dev_data_en_o = pins.drive;
  assign dev_addr_o    = slot_addr;
  assign dev_data_o    = pins.drive ? slot_byte : '0;
endmodule

// File: rtl/prom_prog_seq_chk.sv
module prom_prog_seq_chk #(
  parameter int PULSE_CYC = 8,
  parameter int MAX_TRIES = 10,
  parameter int ATT_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic             fail_i,
  input logic [ATT_W-1:0] attempts_i,
  input logic             ce_i,
  input logic             oe_i,
  input logic             pgm_i,
  input logic             data_en_i
);
  localparam int CW = $clog2(PULSE_CYC + 2);
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt_q <= '0;
    else if (!pgm_i) low_cnt_q <= low_cnt_q + 1'b1;
    else             low_cnt_q <= '0;
  end

  assert_pulse_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_i |-> (low_cnt_q < CW'(PULSE_CYC)));

  assert_pulse_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_i && $past(!pgm_i)) |-> (low_cnt_q == CW'(PULSE_CYC)));

  assert_pulse_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_i |-> (oe_i && data_en_i));

  assert_bus_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !oe_i) |-> !data_en_i);

  assert_result_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && fail_i));

  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempts_i <= ATT_W'(MAX_TRIES));

  assert_fail_at_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |-> (attempts_i == ATT_W'(MAX_TRIES)));

  assert_idle_standby_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (ce_i && oe_i && pgm_i));
endmodule

bind prom_prog_seq prom_prog_seq_chk #(
  .PULSE_CYC (PULSE_CYC),
  .MAX_TRIES (MAX_TRIES),
  .ATT_W     (ATT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .fail_i     (fail_o),
  .attempts_i (attempts_o),
  .ce_i       (dev_ce_o),
  .oe_i       (dev_oe_o),
  .pgm_i      (dev_pgm_o),
  .data_en_i  (dev_data_en_o)
);

// File: tb/prom_prog_seq_test.sv
`timescale 1ns/1ps
module prom_prog_seq_test;
  localparam int AW = 8, DW = 8, PN = 4, PCYC = 8, MAXT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, page = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [PN*DW-1:0] data = '0;
  logic busy, done, fail;
  logic [3:0] att;
  logic ce, oe, pgm, den;
  logic [AW-1:0] daddr;
  logic [DW-1:0] dout, drd;

  always #2.5 clk = ~clk;

  prom_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_N(PN), .PULSE_CYC_OVR(PCYC), .MAX_TRIES(MAXT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page), .addr_i(addr),
    .data_i(data), .busy_o(busy), .done_o(done), .fail_o(fail), .attempts_o(att),
    .dev_ce_o(ce), .dev_oe_o(oe), .dev_pgm_o(pgm), .dev_addr_o(daddr),
    .dev_data_o(dout), .dev_data_en_o(den), .dev_data_i(drd)
  );

  // memory model: a cell takes its data once it has seen need[] pulses
  logic [7:0] mem [256];
  int need [256];
  int pcnt [256];
  logic [7:0] lat_a [4], lat_d [4];
  logic [7:0] log_a [16], log_d [16];
  int latch_ev, pulses, cur_w, last_w, bus_bad;
  logic pgm_prev, pulse_ce;
  logic [7:0] pulse_addr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  assign drd = (!ce && !oe) ? mem[daddr] : 8'h00;

  task automatic dev_write(input logic [7:0] a, input logic [7:0] d);
    pcnt[a]++;
    if (pcnt[a] >= need[a]) mem[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; need[i] = 1; pcnt[i] = 0; end
    latch_ev = 0; pulses = 0; cur_w = 0; last_w = 0; bus_bad = 0;
    pgm_prev = 1'b1; pulse_ce = 1'b1; pulse_addr = '0;
  end

  always @(negedge clk) if (rst_n) begin
    if (ce && pgm && !oe) begin
      lat_a[daddr[1:0]] = daddr; lat_d[daddr[1:0]] = dout;
      log_a[latch_ev % 16] = daddr; log_d[latch_ev % 16] = dout;
      latch_ev++;
    end
    if (den && !ce && !oe) bus_bad++;
    if (!pgm && pgm_prev) begin
      pulses++; pulse_ce = ce; pulse_addr = daddr; cur_w = 0;
      if (ce) for (int k = 0; k < 4; k++) dev_write(lat_a[k], lat_d[k]);
      else dev_write(daddr, dout);
    end
    if (!pgm) cur_w++;
    if (pgm && !pgm_prev) last_w = cur_w;
    pgm_prev = pgm;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    latch_ev = 0; pulses = 0; last_w = 0; bus_bad = 0;
  endtask

  task automatic wait_end();
    int g = 0;
    while (!(done || fail) && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic run_op(input logic pg, input logic [7:0] a, input logic [31:0] d);
    clear_log();
    @(negedge clk);
    start = 1'b1; page = pg; addr = a; data = d;
    @(negedge clk);
    start = 1'b0;
    wait_end();
  endtask

  task automatic t_reset();
    chk("R1 ce", ce, 1); chk("R1 oe", oe, 1); chk("R1 pgm", pgm, 1);
    chk("R1 den", den, 0); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0); chk("R1 fail", fail, 0); chk("R1 att", att, 0);
  endtask

  task automatic t_byte_ok();
    run_op(1'b0, 8'h10, 32'h0000_003C);
    chk("R7 byte done", done, 1); chk("R7 byte att", att, 1);
    chk("R4 byte mem", mem[8'h10], 8'h3C);
    chk("R4 byte no latch", latch_ev, 0);
    chk("R4 pulse ce", pulse_ce, 0); chk("R4 pulse addr", pulse_addr, 8'h10);
    chk("R2 width", last_w, PCYC);
    chk("R5 bus", bus_bad, 0);
    chk("R10 ce", ce, 1); chk("R10 busy", busy, 0);
  endtask

  task automatic t_page_ok();
    run_op(1'b1, 8'h20, 32'hD4C3_B2A1);
    chk("R7 page done", done, 1); chk("R7 page att", att, 1);
    chk("R3 latch count", latch_ev, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R3 latch addr", log_a[k], 8'h20 + 8'(k));
      chk("R3 latch data", log_d[k], 8'(32'hD4C3_B2A1 >> (8*k)));
      chk("R3 mem", mem[8'h20 + 8'(k)], 8'(32'hD4C3_B2A1 >> (8*k)));
    end
    chk("R3 pulse ce", pulse_ce, 1);
    chk("R2 width", last_w, PCYC);
    chk("R5 bus", bus_bad, 0);
  endtask

  task automatic t_page_retry();
    need[8'h42] = 3;
    run_op(1'b1, 8'h40, 32'h4433_2211);
    chk("R6 retry done", done, 1); chk("R6 retry att", att, 3);
    chk("R6 pulses", pulses, 3); chk("R6 no relatch", latch_ev, 4);
    chk("R6 mem", mem[8'h42], 8'h33); chk("R6 mem3", mem[8'h43], 8'h44);
    chk("R5 bus", bus_bad, 0);
  endtask

  task automatic t_byte_fail();
    need[8'h50] = 99;
    run_op(1'b0, 8'h50, 32'h0000_0077);
    chk("R8 fail", fail, 1); chk("R8 not done", done, 0);
    chk("R8 att", att, MAXT); chk("R8 pulses", pulses, MAXT);
    chk("R10 ce", ce, 1);
  endtask

  task automatic t_page_fail_last();
    need[8'h63] = 11;
    run_op(1'b1, 8'h60, 32'h8877_6655);
    chk("R8 page fail", fail, 1); chk("R8 page att", att, MAXT);
    chk("R8 page pulses", pulses, MAXT);
  endtask

  task automatic t_exact_limit();
    need[8'h80] = MAXT;
    run_op(1'b0, 8'h80, 32'h0000_005A);
    chk("R8 tenth ok done", done, 1); chk("R8 tenth ok fail", fail, 0);
    chk("R8 tenth att", att, MAXT); chk("R8 tenth mem", mem[8'h80], 8'h5A);
  endtask

  task automatic t_busy_ignore();
    clear_log();
    @(negedge clk);
    start = 1'b1; page = 1'b0; addr = 8'h70; data = 32'h11;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; page = 1'b1; addr = 8'h71; data = 32'h2222_2222;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk("R9 done", done, 1); chk("R9 att", att, 1); chk("R9 pulses", pulses, 1);
    chk("R9 mem kept", mem[8'h70], 8'h11); chk("R9 mem other", mem[8'h71], 8'hFF);
    chk("R9 latch", latch_ev, 0);
    repeat (3) @(negedge clk);
    chk("R9 stays idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_ok();
    t_page_ok();
    t_page_retry();
    t_byte_fail();
    t_page_fail_last();
    t_exact_limit();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule